// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is a target on a two-wire serial bus (a clock line and an open-drain data line). It gives a bus host read and write access to a bank of 8-bit control registers at indices 0x00 through 0x19. The register values are also presented in parallel on a flat output vector, so neighbouring logic can use them as configuration. Both bus lines are sampled by the system clock through a two-flop synchronizer, and their edges are detected in that clock domain. The block never drives the data line high. It only asserts a pull-down enable, which the pad turns into a low level.

A host starts a transaction and sends a device address byte. In a write, it then sends a base register index followed by data bytes. Each data byte lands at the register pointer, and the pointer then advances. A read continues from wherever an earlier write left the pointer. The usual way to read is a write of the base index, then a repeated start, then a read. The pointer stops at the top register instead of wrapping. A base index beyond the bank is refused, and a host's not-acknowledge during a read ends the data phase.

Top module: `tws_regslave`

## Requirements
- R1: After reset every register reads 0x00, the pull-down enable is low, and the register pointer is 0x00. A read issued before any write therefore returns register 0 first.
- R2: A start condition is recognised when SDA falls while SCL is high. A stop condition is recognised when SDA rises while SCL is high. A stop releases SDA and returns the slave to idle. The register pointer keeps its value across the stop, so a later read resumes from it.
- R3: The first byte after a start holds a 7-bit device address, sent MSB first, followed by a direction bit (1 = read, 0 = write). The device address is binary 100110s, where s is the level of `addr_sel_i`. On a match the slave pulls SDA low for the whole ninth SCL pulse.
- R4: When the device address does not match, SDA stays released on the ninth pulse. The slave then ignores every later byte until the next start: no register changes, no acknowledge, and read bits come back as 1.
- R5: In a write transaction the second byte is the base register index. Each later data byte is acknowledged, stored in the register the pointer selects, and the pointer then advances by one. A write strobe occurs only while SCL is high.
- R6: The pointer never exceeds 0x19. Once it reaches 0x19, every further written byte goes to 0x19 and every further read byte comes from 0x19.
- R7: A base index greater than 0x19 is not acknowledged. Data bytes that follow it in the same transaction are neither acknowledged nor stored, and the pointer keeps its previous value.
- R8: In a read transaction the slave sends the register at the pointer, MSB first, on the eight SCL pulses after the address acknowledge. The pointer advances after each byte is sent. When the host acknowledges, the next byte follows immediately.
- R9: A start that arrives without a preceding stop (a repeated start) is accepted. The slave then expects a new device address byte, so a host can write the base index and switch to reading in one transaction.
- R10: When the host does not acknowledge a read byte, the slave releases SDA and sends nothing more until the next start.
- R11: The pull-down enable only turns on while the synchronized SCL is low, and it never changes while the bus clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| addr_sel_i | input | 1 | Sets the least significant bit of the device address |
| sda_pull_o | output | 1 | Active-high enable for the open-drain pull-down on SDA |
| cfg_o | output | NUM_REGS*8 | All register contents; register k occupies bits [8k+7:8k] |

## Verification
Writes are tried with single bytes, with runs that cross the top of the bank, and with base indices both inside and beyond the bank. This separates the normal pointer step from saturation and from refusal. Reads are tried from the reset pointer, from a pointer set before a stop, and from a pointer set just before a repeated start. These show whether the pointer survives each path and whether data comes out MSB first. Address bytes with the wrong select bit, and with both levels of `addr_sel_i`, check that a foreign transaction is fully ignored. A seeded random mix of these transactions, checked against a model of the register bank and pointer, catches ordering errors that the directed cases miss.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACKOUT,
    ST_SEND,
    ST_ACKIN
  } tws_state_e;

  typedef enum logic [1:0] {
    ROLE_DEV,
    ROLE_REG,
    ROLE_DATA
  } tws_role_e;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] line_in;
  logic [NLINES-1:0] line_s;
  logic [NLINES-1:0] line_d;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES:0] pipe_q;
    logic [STAGES:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[STAGES-1:0], line_in[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= '1;
      end else begin
        pipe_q <= pipe_d;
      end
    end

    assign line_s[g] = pipe_q[STAGES-1];
    assign line_d[g] = pipe_q[STAGES];
  end

  logic scl_d;
  logic sda_d;

  assign scl_s = line_s[0];
  assign sda_s = line_s[1];
  assign scl_d = line_d[0];
  assign sda_d = line_d[1];

  assign scl_rise  =  scl_s & ~scl_d;
  assign scl_fall  = ~scl_s &  scl_d;
  assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
  assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;

endmodule

// File: rtl/tws_regbank.sv
module tws_regbank #(
  parameter int NUM_REGS = 26,
  parameter int PTR_W    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      addr,
  input  logic [7:0]            wr_data,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);

  logic [7:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic       sel_en;
    logic [7:0] reg_d;

    assign sel_en = wr_en && (int'(addr) == g);

    always_comb begin
      reg_d = regs_q[g];
      if (sel_en) begin
        reg_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= 8'h00;
      end else begin
        regs_q[g] <= reg_d;
      end
    end

    assign regs_flat[g*8 +: 8] = regs_q[g];
  end

  always_comb begin
    rd_data = 8'h00;
    if (int'(addr) < NUM_REGS) begin
      rd_data = regs_q[addr];
    end
  end

endmodule

// File: rtl/tws_engine.sv
module tws_engine
  import tws_pkg::*;
#(
  parameter int         NUM_REGS    = 26,
  parameter int         PTR_W       = 5,
  parameter logic [5:0] DEV_ADDR_HI = 6'b100110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             addr_sel,
  input  logic [7:0]       rd_data,
  output logic             pull_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [7:0]       wr_data_o
);

  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(NUM_REGS - 1);
  localparam logic [7:0]       LAST_BYTE = 8'(NUM_REGS - 1);
  localparam logic [3:0]       BITS_LAST = 4'd7;
  localparam logic [3:0]       BITS_DONE = 4'd8;

  tws_state_e       state_q, state_d;
  tws_role_e        role_q,  role_d;
  logic [3:0]       cnt_q,   cnt_d;
  logic [7:0]       shreg_q, shreg_d;
  logic [7:0]       txd_q,   txd_d;
  logic             ack_q,   ack_d;
  logic             rw_q,    rw_d;
  logic             mack_q,  mack_d;
  logic             pull_q,  pull_d;
  logic [PTR_W-1:0] ptr_q,   ptr_d;

  logic [7:0]       byte_full;
  logic [PTR_W-1:0] ptr_step;
  logic             wr_en;

  assign byte_full = {shreg_q[6:0], sda_s};
  assign ptr_step  = (ptr_q == LAST_PTR) ? LAST_PTR : ptr_q + 1'b1;

  always_comb begin
    state_d = state_q;
    role_d  = role_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    txd_d   = txd_q;
    ack_d   = ack_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    pull_d  = pull_q;
    ptr_d   = ptr_q;
    wr_en   = 1'b0;

    if (stop_det) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
    end else if (start_det) begin
      state_d = ST_RECV;
      role_d  = ROLE_DEV;
      cnt_d   = 4'd0;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_RECV: begin
          if (scl_rise) begin
            shreg_d = byte_full;
            cnt_d   = cnt_q + 4'd1;
            if (cnt_q == BITS_LAST) begin
              unique case (role_q)
                ROLE_DEV: begin
                  ack_d = (byte_full[7:1] == {DEV_ADDR_HI, addr_sel});
                  rw_d  = byte_full[0];
                end
                ROLE_REG: begin
                  ack_d = (byte_full <= LAST_BYTE);
                  if (byte_full <= LAST_BYTE) begin
                    ptr_d = byte_full[PTR_W-1:0];
                  end
                end
                default: begin
                  ack_d = 1'b1;
                  wr_en = 1'b1;
                  ptr_d = ptr_step;
                end
              endcase
            end
          end else if (scl_fall && (cnt_q == BITS_DONE)) begin
            if (ack_q) begin
              pull_d  = 1'b1;
              state_d = ST_ACKOUT;
            end else begin
              pull_d  = 1'b0;
              state_d = ST_IDLE;
            end
          end
        end

        ST_ACKOUT: begin
          if (scl_fall) begin
            cnt_d = 4'd0;
            if ((role_q == ROLE_DEV) && rw_q) begin
              txd_d   = rd_data;
              pull_d  = ~rd_data[7];
              state_d = ST_SEND;
            end else begin
              pull_d  = 1'b0;
              state_d = ST_RECV;
              role_d  = (role_q == ROLE_DEV) ? ROLE_REG : ROLE_DATA;
            end
          end
        end

        ST_SEND: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == BITS_DONE) begin
              pull_d  = 1'b0;
              ptr_d   = ptr_step;
              state_d = ST_ACKIN;
            end else begin
              txd_d  = {txd_q[6:0], 1'b0};
              pull_d = ~txd_q[6];
            end
          end
        end

        ST_ACKIN: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            cnt_d = 4'd0;
            if (mack_q) begin
              txd_d   = rd_data;
              pull_d  = ~rd_data[7];
              state_d = ST_SEND;
            end else begin
              pull_d  = 1'b0;
              state_d = ST_IDLE;
            end
          end
        end

        default: begin
          pull_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      role_q  <= ROLE_DEV;
      cnt_q   <= 4'd0;
      shreg_q <= 8'h00;
      txd_q   <= 8'h00;
      ack_q   <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      pull_q  <= 1'b0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      role_q  <= role_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      txd_q   <= txd_d;
      ack_q   <= ack_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      pull_q  <= pull_d;
      ptr_q   <= ptr_d;
    end
  end

  assign pull_o    = pull_q;
  assign wr_en_o   = wr_en;
  assign ptr_o     = ptr_q;
  assign wr_data_o = byte_full;

endmodule

// File: rtl/tws_regslave.sv
module tws_regslave #(
  parameter int         NUM_REGS    = 26,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_ADDR_HI = 6'b100110
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  addr_sel_i,
  output logic                  sda_pull_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);

  localparam int PTR_W = $clog2(NUM_REGS);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  logic             scl_s;
  logic             sda_s;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_det;
  logic             stop_det;
  logic             wr_en;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       wr_data;
  logic [7:0]       rd_data;

  tws_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tws_engine #(
    .NUM_REGS    (NUM_REGS),
    .PTR_W       (PTR_W),
    .DEV_ADDR_HI (DEV_ADDR_HI)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr_sel  (addr_sel_i),
    .rd_data   (rd_data),
    .pull_o    (sda_pull_o),
    .wr_en_o   (wr_en),
    .ptr_o     (ptr),
    .wr_data_o (wr_data)
  );

  tws_regbank #(
    .NUM_REGS (NUM_REGS),
    .PTR_W    (PTR_W)
  ) u_regbank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .addr      (ptr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .regs_flat (cfg_o)
  );

endmodule

// File: rtl/tws_regslave_chk.sv
module tws_regslave_chk #(
  parameter int NUM_REGS = 26,
  parameter int PTR_W    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             stop_det,
  input logic             pull,
  input logic             wr_en,
  input logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_REGS - 1);

  logic [PTR_W-1:0] ptr_after_wr;
  assign ptr_after_wr = (ptr == LAST_PTR) ? LAST_PTR : ptr + 1'b1;

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST_PTR); // R6

  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == $past(ptr_after_wr))); // R5

  AST_WR_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> scl_s); // R5

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !pull); // R2

  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull) |-> !scl_s); // R11

endmodule

bind tws_regslave tws_regslave_chk #(
  .NUM_REGS (NUM_REGS),
  .PTR_W    (PTR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .scl_s    (scl_s),
  .stop_det (stop_det),
  .pull     (sda_pull_o),
  .wr_en    (wr_en),
  .ptr      (ptr)
);

// File: tb/tws_regslave_tb.sv
module tws_regslave_tb;

  localparam int NREG = 26;
  localparam int QTR  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sel = 1'b0;
  logic sda_pull;
  logic sda_line;
  logic [NREG*8-1:0] cfg;

  always #4 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull;

  tws_regslave u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .addr_sel_i (sel),
    .sda_pull_o (sda_pull),
    .cfg_o      (cfg)
  );

  int checks = 0;
  int errors = 0;
  int hi_viol = 0;
  logic [7:0] mem [NREG];
  int mptr = 0;
  logic prev_pull = 1'b0;

  // R11 monitor: pull-down must not move while the master holds SCL high
  always @(negedge clk) begin
    if (rst_n && m_scl && (sda_pull !== prev_pull)) hi_viol++;
    prev_pull = sda_pull;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int sat_inc(int p);
    return (p == NREG - 1) ? p : p + 1;
  endfunction

  function automatic logic [7:0] dev_byte(bit good, bit rw);
    return {6'b100110, (good ? sel : ~sel), rw};
  endfunction

  task automatic wq();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic put_bit(bit b);
    m_sda = b; wq();
    m_scl = 1'b1; wq(); wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic get_bit(output bit b);
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    b = sda_line; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic put_byte(logic [7:0] d, output bit acked);
    bit nb;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(nb);
    acked = !nb;
  endtask

  task automatic get_byte(output logic [7:0] d, input bit give_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!give_ack);
  endtask

  task automatic cmp_bank(string req);
    int bad = 0;
    for (int k = 0; k < NREG; k++) if (cfg[k*8 +: 8] !== mem[k]) bad++;
    chk(req, "register bank mismatches", bad, 0);
  endtask

  task automatic do_write(bit good, int base, int n, logic [7:0] d0, logic [7:0] d1,
                          logic [7:0] d2, logic [7:0] d3);
    bit a;
    logic [7:0] dv [4];
    dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
    bus_start();
    put_byte(dev_byte(good, 1'b0), a);
    chk(good ? "R3" : "R4", "device address ack", a, good);
    put_byte(8'(base), a);
    if (!good) begin
      chk("R4", "ack after foreign address", a, 0);
      put_byte(d0, a);
      chk("R4", "data ack after foreign address", a, 0);
    end else if (base < NREG) begin
      chk("R5", "base index ack", a, 1);
      mptr = base;
      for (int i = 0; i < n; i++) begin
        put_byte(dv[i], a);
        chk("R5", "data byte ack", a, 1);
        mem[mptr] = dv[i];
        mptr = sat_inc(mptr);
      end
    end else begin
      chk("R7", "out-of-range base ack", a, 0);
      put_byte(d0, a);
      chk("R7", "data ack after refused base", a, 0);
    end
    bus_stop();
    wq();
    cmp_bank(good ? ((base < NREG) ? "R6" : "R7") : "R4");
  endtask

  task automatic do_read(bit good, int n, bit set_ptr, int base);
    bit a;
    logic [7:0] d;
    if (set_ptr) begin
      bus_start();
      put_byte(dev_byte(1'b1, 1'b0), a);
      chk("R3", "device address ack before read", a, 1);
      put_byte(8'(base), a);
      chk("R9", "base index ack before repeated start", a, 1);
      mptr = base;
    end
    bus_start();
    put_byte(dev_byte(good, 1'b1), a);
    chk(good ? "R9" : "R4", "read address ack", a, good);
    if (good) begin
      for (int i = 0; i < n; i++) begin
        get_byte(d, i < n - 1);
        chk("R8", "read byte", d, mem[mptr]);
        mptr = sat_inc(mptr);
      end
      wq();
      chk("R10", "pull-down after host not-acknowledge", sda_pull, 0);
    end else begin
      get_byte(d, 1'b0);
      chk("R4", "read after foreign address", d, 8'hFF);
    end
    bus_stop();
    wq();
    chk("R2", "pull-down after stop", sda_pull, 0);
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) mem[k] = 8'h00;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    chk("R1", "pull-down after reset", sda_pull, 0);
    chk("R1", "register bank after reset", (cfg == '0), 1);

    // R1/R8: read before any write starts at register 0
    do_read(1'b1, 2, 1'b0, 0);
    // R6: run across the top of the bank
    do_write(1'b1, 8'h17, 4, 8'hA1, 8'hB2, 8'hC3, 8'hD4);
    chk("R6", "top register holds last byte", cfg[25*8 +: 8], 8'hD4);
    // R9/R6: repeated start read crossing the top
    do_read(1'b1, 3, 1'b1, 8'h18);
    // R7: refused base index
    do_write(1'b1, 8'h1A, 1, 8'h55, 8'h00, 8'h00, 8'h00);
    // R4: foreign device address
    do_write(1'b0, 3, 1, 8'h66, 8'h00, 8'h00, 8'h00);
    // R2: pointer survives a stop
    do_write(1'b1, 5, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    do_write(1'b1, 5, 2, 8'h3C, 8'hC3, 8'h00, 8'h00);
    do_write(1'b1, 5, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    do_read(1'b1, 2, 1'b0, 0);
    // R3: other level of the select pin
    sel = 1'b1;
    do_write(1'b1, 2, 2, 8'h81, 8'h7E, 8'h00, 8'h00);
    do_read(1'b1, 3, 1'b1, 1);
    do_read(1'b0, 1, 1'b0, 0);

    for (int it = 0; it < 24; it++) begin
      int r;
      r = $urandom_range(0, 9);
      if ($urandom_range(0, 3) == 0) sel = ~sel;
      if (r < 5) begin
        do_write(r != 0, $urandom_range(0, NREG + 3), $urandom_range(1, 4),
                 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      end else begin
        do_read(r != 5, $urandom_range(1, 4), 1'($urandom_range(0, 1)),
                $urandom_range(0, NREG - 1));
      end
    end

    chk("R11", "pull-down changes while SCL high", hi_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule